// File: doc/BRIEF.md
# SPI Receive Snoop Ring with Chip-Select Hold

This block sits next to an SPI master and listens to its data-in line. Any transaction counts, including generic command cycles that are not memory accesses. Each bit is taken on the serial clock edge picked by a control bit. Eight bits make a byte, and the byte is stored bit-mirrored, so the first bit on the wire lands in bit 0. Bytes are packed into 64-bit slots from the low byte upward. The slots form a ring of 32 entries that a host reads over a simple register bus.

A control word at byte offset 0x210 switches reception on and selects the sampling edge. It also carries a mask with one bit per chip select. A set mask bit keeps that chip select asserted after the master lets it go. Software can therefore stretch one transaction across several master commands when the total length is not known in advance. Clearing receive enable lets every held line go. Writing soft reset and start in the same write rewinds the ring to slot 0.

Top module: `miso_capture_ring`

## Requirements
- R1: The control word sits at byte address 0x210, and all of its fields reset to 0. Bit 1 is drive polarity and bit 2 is capture polarity. Bit 3 is function enable and bit 4 is receive enable. Bits 9:6 are the hold mask, with bit 6+i belonging to chip select i, and bit 11 is soft reset. Bit 0 is start, a write-only pulse that reads as 0, and the remaining bits read as 0.
- R2: A bit is captured only while receive enable is 1 and at least one chip-select output is low. Capture polarity 1 takes the bit on the rising edge of the serial clock, and capture polarity 0 takes it on the falling edge.
- R3: The first bit of a byte on the wire is stored in bit 0 of that byte, and the eighth bit is stored in bit 7.
- R4: Byte k of a slot (k = 0..7) lives in bits 8k+7:8k. Slot i is read at byte address 8*i, and the read data appears on the bus one clock after the read strobe.
- R5: The write slot advances by one after every eighth captured byte, and it wraps from slot 31 to slot 0.
- R6: A transaction ends when all chip-select outputs have gone high after one was low. If it ends with 1 to 7 bytes in the open slot, that slot is written with its unfilled bytes set to zero, and the write slot advances. Leftover bits of an incomplete byte are dropped.
- R7: While hold bit i and receive enable are both 1, chip-select output i stays low once it has gone low, even after the master drives its own chip select i high.
- R8: While hold bit i or receive enable is 0, chip-select output i equals the master's chip select i.
- R9: A control write with bit 0 and bit 11 both set returns the write slot to 0 and discards any partly captured byte and slot.
- R10: After reset, the read data is 0 and every chip-select output follows the master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe |
| bus_addr | input | 10 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 64 | Host read data, registered |
| spi_sclk_i | input | 1 | Serial clock from the master |
| spi_miso_i | input | 1 | Serial data-in line |
| ctl_cs_n_i | input | 4 | Chip selects requested by the master, active low |
| cs_n_o | output | 4 | Chip selects to the devices, active low |
| sclk_drive_pol_o | output | 1 | Drive polarity field, passed to the master |
| fn_en_o | output | 1 | Function enable field, passed to the master |

## Verification
The assertions check the chip-select rules on every cycle: a held line cannot rise, and a line that is not held always follows the master. They also check every cycle that the write slot only ever steps by one or returns to 0, that it stays put while reception is off, and that it is 0 right after a rewind. Bit mirroring, byte placement, flushing of a partial slot, the choice of sampling edge and the wrap of the ring show up only in the data the bench reads back after its transaction sweeps. The bench's serial model changes the data line between the two clock edges, so sampling on the wrong edge shows up as corrupted bytes.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int unsigned CTRL_ADDR = 'h210;
  localparam int unsigned CTRL_W    = 12;
  localparam int unsigned B_START   = 0;
  localparam int unsigned B_DRVPOL  = 1;
  localparam int unsigned B_CAPPOL  = 2;
  localparam int unsigned B_FNEN    = 3;
  localparam int unsigned B_RXEN    = 4;
  localparam int unsigned B_HOLD0   = 6;
  localparam int unsigned HOLD_MAX  = 4;
  localparam int unsigned B_SRST    = 11;
endpackage

// File: rtl/mcr_ctrl_regs.sv
module mcr_ctrl_regs
  import mcr_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned WD_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WD_W-1:0]   bus_wdata,
  output logic              drv_pol,
  output logic              cap_pol,
  output logic              fn_en,
  output logic              rx_en,
  output logic [NUM_CS-1:0] hold_mask,
  output logic              clr_pulse,
  output logic [CTRL_W-1:0] ctrl_img
);
  logic              wr_hit;
  logic              drv_pol_q, cap_pol_q, fn_en_q, rx_en_q, srst_q;
  logic              drv_pol_n, cap_pol_n, fn_en_n, rx_en_n, srst_n;
  logic [NUM_CS-1:0] hold_q, hold_n;
  logic              unused_wd;

  assign wr_hit    = bus_we && (32'(bus_addr) == CTRL_ADDR);
  assign unused_wd = ^bus_wdata;

  always_comb begin
    drv_pol_n = drv_pol_q;
    cap_pol_n = cap_pol_q;
    fn_en_n   = fn_en_q;
    rx_en_n   = rx_en_q;
    srst_n    = srst_q;
    hold_n    = hold_q;
    if (wr_hit) begin
      drv_pol_n = bus_wdata[B_DRVPOL];
      cap_pol_n = bus_wdata[B_CAPPOL];
      fn_en_n   = bus_wdata[B_FNEN];
      rx_en_n   = bus_wdata[B_RXEN];
      srst_n    = bus_wdata[B_SRST];
      hold_n    = bus_wdata[B_HOLD0 +: NUM_CS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_pol_q <= 1'b0;
      cap_pol_q <= 1'b0;
      fn_en_q   <= 1'b0;
      rx_en_q   <= 1'b0;
      srst_q    <= 1'b0;
      hold_q    <= '0;
    end else if (wr_hit) begin
      drv_pol_q <= drv_pol_n;
      cap_pol_q <= cap_pol_n;
      fn_en_q   <= fn_en_n;
      rx_en_q   <= rx_en_n;
      srst_q    <= srst_n;
      hold_q    <= hold_n;
    end
  end

  // rewind request: start and soft reset in the same write
  assign clr_pulse = wr_hit && bus_wdata[B_START] && bus_wdata[B_SRST];

  always_comb begin
    ctrl_img                    = '0;
    ctrl_img[B_DRVPOL]          = drv_pol_q;
    ctrl_img[B_CAPPOL]          = cap_pol_q;
    ctrl_img[B_FNEN]            = fn_en_q;
    ctrl_img[B_RXEN]            = rx_en_q;
    ctrl_img[B_SRST]            = srst_q;
    ctrl_img[B_HOLD0 +: NUM_CS] = hold_q;
  end

  assign drv_pol   = drv_pol_q;
  assign cap_pol   = cap_pol_q;
  assign fn_en     = fn_en_q;
  assign rx_en     = rx_en_q;
  assign hold_mask = hold_q;
endmodule

// File: rtl/mcr_cs_hold.sv
module mcr_cs_hold #(
  parameter int unsigned NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CS-1:0] ctl_cs_n_raw,
  input  logic [NUM_CS-1:0] ctl_cs_n_s,
  input  logic [NUM_CS-1:0] hold_mask,
  input  logic              rx_en,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic [NUM_CS-1:0] cs_eff_s,
  output logic              bus_act,
  output logic              txn_end
);
  logic [NUM_CS-1:0] held_q, held_n, gate;
  logic              act_q;

  always_comb begin
    for (int i = 0; i < NUM_CS; i++) begin
      held_n[i] = hold_mask[i] && rx_en && (held_q[i] || !ctl_cs_n_s[i]);
      gate[i]   = held_q[i] && hold_mask[i] && rx_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      act_q  <= 1'b0;
    end else begin
      held_q <= held_n;
      act_q  <= bus_act;
    end
  end

  assign cs_n_o   = ctl_cs_n_raw & ~gate;
  assign cs_eff_s = ctl_cs_n_s & ~gate;
  assign bus_act  = |(~cs_eff_s);
  assign txn_end  = act_q && !bus_act;
endmodule

// File: rtl/mcr_assembler.sv
module mcr_assembler #(
  parameter int unsigned QW    = 64,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned NBYTES = QW / 8,
  localparam int unsigned BCW    = $clog2(NBYTES),
  localparam int unsigned PW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          miso_s,
  input  logic          cap_pol,
  input  logic          cap_en,
  input  logic          txn_end,
  input  logic          clr,
  output logic          wr_en,
  output logic [PW-1:0] wr_ptr,
  output logic [QW-1:0] wr_data
);
  logic          sclk_d;
  logic [2:0]    bit_q, bit_n;
  logic [7:0]    byte_q, byte_n;
  logic [BCW-1:0] bcnt_q, bcnt_n;
  logic [QW-1:0] qw_q, qw_n;
  logic [PW-1:0] ptr_q, ptr_n;
  logic          samp;

  assign samp = cap_pol ? (sclk_s && !sclk_d) : (!sclk_s && sclk_d);

  always_comb begin
    bit_n   = bit_q;
    byte_n  = byte_q;
    bcnt_n  = bcnt_q;
    qw_n    = qw_q;
    ptr_n   = ptr_q;
    wr_en   = 1'b0;
    wr_data = qw_q;
    if (clr) begin
      bit_n  = '0;
      byte_n = '0;
      bcnt_n = '0;
      qw_n   = '0;
      ptr_n  = '0;
    end else if (txn_end) begin
      if (bcnt_q != '0) begin
        wr_en = 1'b1;
        ptr_n = ptr_q + 1'b1;
      end
      bit_n  = '0;
      byte_n = '0;
      bcnt_n = '0;
      qw_n   = '0;
    end else if (cap_en && samp) begin
      byte_n[bit_q] = miso_s;
      if (bit_q == 3'd7) begin
        bit_n = '0;
        qw_n[bcnt_q*8 +: 8] = byte_n;
        byte_n = '0;
        if (bcnt_q == BCW'(NBYTES - 1)) begin
          wr_en   = 1'b1;
          wr_data = qw_n;
          ptr_n   = ptr_q + 1'b1;
          qw_n    = '0;
          bcnt_n  = '0;
        end else begin
          bcnt_n = bcnt_q + 1'b1;
        end
      end else begin
        bit_n = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      bit_q  <= '0;
      byte_q <= '0;
      bcnt_q <= '0;
      qw_q   <= '0;
      ptr_q  <= '0;
    end else begin
      sclk_d <= sclk_s;
      bit_q  <= bit_n;
      byte_q <= byte_n;
      bcnt_q <= bcnt_n;
      qw_q   <= qw_n;
      ptr_q  <= ptr_n;
    end
  end

  assign wr_ptr = ptr_q;
endmodule

// File: rtl/mcr_store.sv
module mcr_store
  import mcr_pkg::*;
#(
  parameter int unsigned QW     = 64,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_idx,
  input  logic [QW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CTRL_W-1:0] ctrl_img,
  output logic [QW-1:0]     rd_data
);
  logic [QW-1:0] mem [DEPTH];
  logic [QW-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_comb begin
    rd_mux = '0;
    if (32'(rd_addr) == CTRL_ADDR) rd_mux = QW'(ctrl_img);
    else if (32'(rd_addr) < DEPTH * 8) rd_mux = mem[rd_addr[PW+2:3]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/miso_capture_ring.sv
module miso_capture_ring
  import mcr_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned QW     = 64,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned WD_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WD_W-1:0]   bus_wdata,
  output logic [QW-1:0]     bus_rdata,
  input  logic              spi_sclk_i,
  input  logic              spi_miso_i,
  input  logic [NUM_CS-1:0] ctl_cs_n_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              sclk_drive_pol_o,
  output logic              fn_en_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned SW = NUM_CS + 2;

  logic [SW-1:0]     sync1_q, sync2_q;
  logic              sclk_s, miso_s;
  logic [NUM_CS-1:0] ctl_cs_n_s, cs_eff_s, hold_mask;
  logic              cap_pol, rx_en, clr_pulse, bus_act, txn_end, wr_en;
  logic [PW-1:0]     wr_ptr;
  logic [QW-1:0]     wr_data;
  logic [CTRL_W-1:0] ctrl_img;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= {{NUM_CS{1'b1}}, 2'b00};
      sync2_q <= {{NUM_CS{1'b1}}, 2'b00};
    end else begin
      sync1_q <= {ctl_cs_n_i, spi_miso_i, spi_sclk_i};
      sync2_q <= sync1_q;
    end
  end

  assign sclk_s     = sync2_q[0];
  assign miso_s     = sync2_q[1];
  assign ctl_cs_n_s = sync2_q[SW-1:2];

  mcr_ctrl_regs #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .WD_W(WD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .drv_pol(sclk_drive_pol_o), .cap_pol(cap_pol),
    .fn_en(fn_en_o), .rx_en(rx_en), .hold_mask(hold_mask),
    .clr_pulse(clr_pulse), .ctrl_img(ctrl_img)
  );

  mcr_cs_hold #(.NUM_CS(NUM_CS)) u_hold (
    .clk(clk), .rst_n(rst_n), .ctl_cs_n_raw(ctl_cs_n_i),
    .ctl_cs_n_s(ctl_cs_n_s), .hold_mask(hold_mask), .rx_en(rx_en),
    .cs_n_o(cs_n_o), .cs_eff_s(cs_eff_s), .bus_act(bus_act),
    .txn_end(txn_end)
  );

  mcr_assembler #(.QW(QW), .DEPTH(DEPTH)) u_asm (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .miso_s(miso_s),
    .cap_pol(cap_pol), .cap_en(rx_en && bus_act), .txn_end(txn_end),
    .clr(clr_pulse), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data)
  );

  mcr_store #(.QW(QW), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_ptr),
    .wr_data(wr_data), .rd_en(bus_re), .rd_addr(bus_addr),
    .ctrl_img(ctrl_img), .rd_data(bus_rdata)
  );
endmodule

// File: rtl/mcr_chk.sv
module mcr_chk #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned PW    = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] cs_n_o,
  input logic [NUM_CS-1:0] ctl_cs_n_i,
  input logic [NUM_CS-1:0] cs_eff_s,
  input logic [NUM_CS-1:0] hold_mask,
  input logic              rx_en,
  input logic              clr_pulse,
  input logic              txn_end,
  input logic [PW-1:0]     wr_ptr
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    AST_HELD_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!cs_eff_s[g] && hold_mask[g] && rx_en) && hold_mask[g] && rx_en)
        |-> !cs_n_o[g]); // R7
    AST_UNHELD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !(hold_mask[g] && rx_en) |-> (cs_n_o[g] == ctl_cs_n_i[g])); // R8
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr != $past(wr_ptr)) |-> (wr_ptr == PW'($past(wr_ptr) + 1'b1) || wr_ptr == '0)); // R5
  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !clr_pulse && !txn_end) |=> $stable(wr_ptr)); // R2
  AST_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (wr_ptr == '0)); // R9
endmodule

bind miso_capture_ring mcr_chk #(.NUM_CS(NUM_CS), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .ctl_cs_n_i(ctl_cs_n_i),
  .cs_eff_s(cs_eff_s), .hold_mask(hold_mask), .rx_en(rx_en),
  .clr_pulse(clr_pulse), .txn_end(txn_end), .wr_ptr(wr_ptr)
);

// File: tb/sim_miso_capture_ring.sv
module sim_miso_capture_ring;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 4;
  localparam int NSLOT = 32;

  logic        clk, rst_n;
  logic        bus_we, bus_re;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [63:0] bus_rdata;
  logic        sclk, miso;
  logic [NCS-1:0] ctl_cs_n, cs_n_o;
  logic        drv_pol, fn_en;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_mem [NSLOT];
  int ptr = 0;
  int fill = 0;

  miso_capture_ring u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk_i(sclk), .spi_miso_i(miso), .ctl_cs_n_i(ctl_cs_n),
    .cs_n_o(cs_n_o), .sclk_drive_pol_o(drv_pol), .fn_en_o(fn_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 10'h210; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [63:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = 10'(a);
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] mirror(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // rising-edge capture sees the low-phase value, falling sees the high-phase value
  task automatic spi_bit(input logic b, input logic rise);
    miso = rise ? b : ~b;
    idle(3); sclk = 1'b1; idle(3);
    miso = rise ? ~b : b;
    idle(3); sclk = 1'b0; idle(3);
  endtask

  task automatic spi_byte(input logic [7:0] b, input logic rise);
    for (int i = 7; i >= 0; i--) spi_bit(b[i], rise);
  endtask

  task automatic model_push(input logic [7:0] b);
    if (fill == 0) exp_mem[ptr] = '0;
    exp_mem[ptr][8*fill +: 8] = mirror(b);
    fill++;
    if (fill == 8) begin fill = 0; ptr = (ptr + 1) % NSLOT; end
  endtask

  task automatic model_end();
    if (fill != 0) begin fill = 0; ptr = (ptr + 1) % NSLOT; end
  endtask

  task automatic check_slots(input int first, input int cnt, input string req);
    logic [63:0] d;
    for (int j = 0; j < cnt; j++) begin
      rd(8 * ((first + j) % NSLOT), d);
      chk(req, d, exp_mem[(first + j) % NSLOT]);
    end
  endtask

  task automatic txn(input int cs, input int n, input int seed, input logic rise, input logic record);
    logic [7:0] b;
    int first;
    first = ptr;
    ctl_cs_n[cs] = 1'b0;
    idle(4);
    for (int k = 0; k < n; k++) begin
      b = 8'((seed * 29 + k * 53 + 7) & 255);
      spi_byte(b, rise);
      if (record) model_push(b);
    end
    idle(4);
    ctl_cs_n[cs] = 1'b1;
    idle(8);
    if (record) begin
      model_end();
      check_slots(first, (n + 7) / 8, "R3/R4/R5/R6 slot contents");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    int first;
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
    sclk = 1'b0; miso = 1'b0; ctl_cs_n = '1;
    idle(4);
    chk("R10 read data after reset", bus_rdata, 64'h0);
    chk("R10 cs outputs follow", 64'(cs_n_o), 64'hF);
    rst_n = 1'b1;
    idle(2);
    rd('h210, d);
    chk("R1 control resets to zero", d, 64'h0);

    // R1 field map: start reads 0, reserved bits read 0
    wr(32'hFFFF_FFFF);
    rd('h210, d);
    chk("R1 control readback", d, 64'hBDE);
    chk("R1 drive polarity output", 64'(drv_pol), 64'h1);
    chk("R1 function enable output", 64'(fn_en), 64'h1);
    wr(32'h0);
    rd('h210, d);
    chk("R1 control cleared", d, 64'h0);

    // R2/R3/R4/R5/R6: sweep lengths 1..20 with rising-edge capture, ring wraps
    wr(32'h815);
    ptr = 0; fill = 0;
    for (int n = 1; n <= 20; n++) txn(n % NCS, n, n, 1'b1, 1'b1);
    chk("R5 ring wrapped past slot 31", 64'(ptr), 64'd4);

    // R2: falling-edge capture
    wr(32'h810);
    for (int n = 5; n <= 12; n++) txn(n % NCS, n, n + 40, 1'b0, 1'b1);

    // R2: receive disabled, traffic must not move the ring
    wr(32'h800);
    txn(2, 8, 77, 1'b0, 1'b0);
    wr(32'h810);
    txn(1, 8, 78, 1'b0, 1'b1);

    // R9: rewind mid-byte, partial data discarded
    wr(32'h815);
    ptr = 0; fill = 0;
    ctl_cs_n[0] = 1'b0;
    idle(4);
    spi_byte(8'hA5, 1'b1); spi_byte(8'h3C, 1'b1);
    spi_bit(1'b1, 1'b1); spi_bit(1'b0, 1'b1); spi_bit(1'b1, 1'b1);
    wr(32'h815);
    for (int k = 0; k < 8; k++) begin
      spi_byte(8'(k * 17 + 1), 1'b1);
      model_push(8'(k * 17 + 1));
    end
    idle(4); ctl_cs_n[0] = 1'b1; idle(8);
    model_end();
    check_slots(0, 1, "R9 rewind lands in slot 0");
    chk("R9 pointer after rewind", 64'(ptr), 64'd1);

    // R7/R8: hold on chip select 1
    wr(32'h895);
    ptr = 0; fill = 0;
    first = 0;
    ctl_cs_n[1] = 1'b0;
    idle(4);
    for (int k = 0; k < 3; k++) begin spi_byte(8'(k + 200), 1'b1); model_push(8'(k + 200)); end
    idle(4); ctl_cs_n[1] = 1'b1; idle(6);
    chk("R7 held low after master release", 64'(cs_n_o[1]), 64'h0);
    for (int k = 3; k < 9; k++) begin spi_byte(8'(k + 200), 1'b1); model_push(8'(k + 200)); end
    chk("R7 still held during extension", 64'(cs_n_o[1]), 64'h0);
    // R8: unheld line follows the master while line 1 is held
    ctl_cs_n[2] = 1'b0;
    #1;
    chk("R8 unheld line low", 64'(cs_n_o[2]), 64'h0);
    ctl_cs_n[2] = 1'b1;
    #1;
    chk("R8 unheld line high", 64'(cs_n_o[2]), 64'h1);
    idle(2);
    wr(32'h084);
    #1;
    chk("R8 release when receive disabled", 64'(cs_n_o[1]), 64'h1);
    idle(8);
    model_end();
    check_slots(first, 2, "R6 hold transaction with partial slot");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule